// File: doc/BRIEF.md
# Buck Switching Cycle Sequencer

This block sequences the two gate commands of one synchronous buck channel under peak-current control. A switching cycle begins with a one-clock pulse on `cyc_start`. The high-side gate turns on at that point and turns off when the peak-current comparator trips. After a dead time of a fixed number of fast-clock periods with both gates low, the low-side gate turns on and stays on until the next cycle begins. Leaving the low side for the high side uses the same dead time. The comparators and the gate drivers sit outside this block and reach it as plain digital levels.

When the comparator does not trip in time, the channel is in dropout. The high side stays on across cycle boundaries. Every fourth cycle, however, is cut to a fixed share of the period (95% by default). This gives the bootstrap capacitor a low-side window in which to recharge, so the channel effectively switches at one quarter of the cycle rate. With forced-continuous operation deselected, a zero-crossing indication ends the low-side phase early, and both gates then rest until the next cycle. All pins are plain control levels. No data stream passes through the block, so it has no valid/ready handshake.

The position within a cycle is counted in fast-clock periods. Position 0 is the first period after the clock edge that samples `cyc_start`. The cap point is `CAP = CYC_LEN*CAP_PCT/100` (190 with defaults `CYC_LEN=200`, `CAP_PCT=95`), and the dead time is `DEAD_CNT` periods (default 4). Cycles are numbered modulo 4. The first cycle start after enable is cycle 0.

Top module: `buck_cycle_seq`

## Requirements
- R1: While `en` is low, both gates and `dropout` are low one clock edge later. The cycle numbering restarts, so the first cycle start after re-enable is cycle 0.
- R2: A sampled `cyc_start` with `en` high, while the low side is off, drives `hs_gate` high from the next period, which is position 0.
- R3: A `pk_trip` sampled while the high side is on drives `hs_gate` low at the next edge. Both gates then stay low for exactly `DEAD_CNT` periods, after which `ls_gate` goes high.
- R4: The low side stays on until a cycle start. At that cycle start `ls_gate` drops, both gates stay low for `DEAD_CNT` periods, and then `hs_gate` goes high.
- R5: With `fccm` low, a `zc_det` sampled while the low side is on drives `ls_gate` low at the next edge. Both gates then stay low until the next cycle start, which turns the high side on at once.
- R6: With `fccm` high, `zc_det` has no effect on `ls_gate`.
- R7: If the high side is still on at the edge that samples position CAP-1 and `pk_trip` is low, `dropout` goes high. Without a trip, the high side stays on through the following cycle start.
- R8: In every cycle whose number is 3 (modulo 4), `hs_gate` is low from position CAP onward. Dead time follows, then the low side stays on until the next cycle start.
- R9: A `pk_trip` sampled while the high side is on at a position of CAP-1 or less clears `dropout`. A trip sampled exactly at position CAP-1 does not set it.
- R10: `hs_gate` and `ls_gate` are never high in the same period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable |
| cyc_start | input | 1 | One-clock pulse at the start of each switching cycle |
| pk_trip | input | 1 | Peak-current comparator has tripped |
| zc_det | input | 1 | Inductor-current zero crossing detected |
| fccm | input | 1 | Forced-continuous select (external clock or static high sync) |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |
| dropout | output | 1 | Channel is running in dropout |

## Verification
The properties assume that `cyc_start` is a single-clock pulse arriving once per `CYC_LEN` clocks, and that the cap point lies more than `DEAD_CNT` periods before the cycle end. Under those assumptions a refresh cycle always reaches its low-side window. The comparator inputs are treated as arbitrary levels that are acted on only in the phase where they matter. The stimulus issues cycle starts through a single task that spaces them exactly `CYC_LEN` clocks apart, and changes the comparator inputs only between clock edges at chosen positions inside a cycle.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

  // Switching phases of one buck cycle
  typedef enum logic [2:0] {
    PH_REST   = 3'd0,  // both gates low, waiting for a cycle start
    PH_HIGH   = 3'd1,  // high side conducting
    PH_GAP_HL = 3'd2,  // dead time, high side -> low side
    PH_LOW    = 3'd3,  // low side conducting
    PH_GAP_LH = 3'd4   // dead time, low side -> high side
  } phase_e;

endpackage

// File: rtl/buck_seq_timer.sv
module buck_seq_timer #(
  parameter int CYC_LEN       = 200,
  parameter int CAP_PCT       = 95,
  parameter int REFRESH_EVERY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cyc_start,
  output logic before_cap,
  output logic at_cap,
  output logic refresh_cyc
);

  localparam int POS_W = $clog2(CYC_LEN + 1) + 1;
  localparam int CAP   = (CYC_LEN * CAP_PCT) / 100;
  localparam int IDX_W = (REFRESH_EVERY > 1) ? $clog2(REFRESH_EVERY) : 1;
  localparam logic [POS_W-1:0] CAP_V  = POS_W'(CAP);
  localparam logic [POS_W-1:0] LAST_V = POS_W'(CAP - 1);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(REFRESH_EVERY - 1);

  logic [POS_W-1:0] pos;
  logic [IDX_W-1:0] idx;

  // Position inside the current cycle, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pos <= '0;
    else if (!en)           pos <= '0;
    else if (cyc_start)     pos <= '0;
    else if (pos != '1)     pos <= pos + 1'b1;
  end

  // Cycle number; parked on the top value so the first start yields 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             idx <= TOP_IDX;
    else if (!en)           idx <= TOP_IDX;
    else if (cyc_start)     idx <= (idx == TOP_IDX) ? '0 : idx + 1'b1;
  end

  assign before_cap  = (pos < CAP_V);
  assign at_cap      = (pos == LAST_V);
  assign refresh_cyc = (idx == TOP_IDX);

  // R1: a cycle start always lands on position 0 of a fresh cycle
  assert_start_clears_pos_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cyc_start) |=> (before_cap && !at_cap));

endmodule

// File: rtl/buck_seq_dead.sv
module buck_seq_dead #(
  parameter int DEAD_CNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);

  localparam int DW = $clog2(DEAD_CNT + 1);
  localparam logic [DW-1:0] LAST = DW'(DEAD_CNT - 1);

  logic [DW-1:0] cnt;

  assign done = active && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!active) cnt <= '0;
    else if (done)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/buck_seq_fsm.sv
module buck_seq_fsm
  import buck_seq_pkg::*;
#(
  parameter int DEAD_CNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cyc_start,
  input  logic pk_trip,
  input  logic zc_det,
  input  logic fccm,
  input  logic before_cap,
  input  logic at_cap,
  input  logic refresh_cyc,
  input  logic dt_done,
  output logic dt_active,
  output logic hs_gate,
  output logic ls_gate,
  output logic dropout
);

  localparam int GW = $clog2(DEAD_CNT + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(DEAD_CNT);

  phase_e ph, ph_nxt;

  always_comb begin
    ph_nxt = ph;
    unique case (ph)
      PH_REST:   if (cyc_start) ph_nxt = PH_HIGH;
      PH_HIGH: begin
        if (cyc_start)                           ph_nxt = PH_HIGH;
        else if (pk_trip || (refresh_cyc && at_cap)) ph_nxt = PH_GAP_HL;
      end
      PH_GAP_HL: begin
        if (cyc_start)    ph_nxt = PH_HIGH;
        else if (dt_done) ph_nxt = PH_LOW;
      end
      PH_LOW: begin
        if (cyc_start)            ph_nxt = PH_GAP_LH;
        else if (zc_det && !fccm) ph_nxt = PH_REST;
      end
      PH_GAP_LH: if (dt_done) ph_nxt = PH_HIGH;
      default:   ph_nxt = PH_REST;
    endcase
    if (!en) ph_nxt = PH_REST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_REST;
    else        ph <= ph_nxt;
  end

  // Dropout tracking: set when the high side survives to the cap point
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   dropout <= 1'b0;
    else if (!en)                                 dropout <= 1'b0;
    else if (ph == PH_HIGH && pk_trip && before_cap) dropout <= 1'b0;
    else if (ph == PH_HIGH && at_cap && !pk_trip) dropout <= 1'b1;
  end

  assign hs_gate   = (ph == PH_HIGH);
  assign ls_gate   = (ph == PH_LOW);
  assign dt_active = (ph == PH_GAP_HL) || (ph == PH_GAP_LH);

  // Observation of the gate outputs for the dead-time properties
  logic [GW-1:0] gap;
  logic          ls_was_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap         <= '0;
      ls_was_last <= 1'b0;
    end else begin
      if (hs_gate || ls_gate) gap <= '0;
      else if (gap != GAP_MAX) gap <= gap + 1'b1;
      if (ls_gate)      ls_was_last <= 1'b1;
      else if (hs_gate) ls_was_last <= 1'b0;
    end
  end

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  assert_dead_before_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> (gap >= GAP_MAX));

  assert_dead_before_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_gate) && ls_was_last) |-> (gap >= GAP_MAX));

  assert_disable_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hs_gate && !ls_gate && !dropout));

  assert_start_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cyc_start && !ls_gate) |=> hs_gate);

  assert_zero_cross_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_gate && zc_det && !fccm) |=> !ls_gate);

  assert_refresh_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_cyc && !before_cap) |-> !hs_gate);

endmodule

// File: rtl/buck_cycle_seq.sv
module buck_cycle_seq #(
  parameter int CYC_LEN       = 200,
  parameter int CAP_PCT       = 95,
  parameter int DEAD_CNT      = 4,
  parameter int REFRESH_EVERY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cyc_start,
  input  logic pk_trip,
  input  logic zc_det,
  input  logic fccm,
  output logic hs_gate,
  output logic ls_gate,
  output logic dropout
);

  logic before_cap, at_cap, refresh_cyc;
  logic dt_active, dt_done;

  buck_seq_timer #(
    .CYC_LEN       (CYC_LEN),
    .CAP_PCT       (CAP_PCT),
    .REFRESH_EVERY (REFRESH_EVERY)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .cyc_start   (cyc_start),
    .before_cap  (before_cap),
    .at_cap      (at_cap),
    .refresh_cyc (refresh_cyc)
  );

  buck_seq_dead #(
    .DEAD_CNT (DEAD_CNT)
  ) u_dead (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (dt_active),
    .done   (dt_done)
  );

  buck_seq_fsm #(
    .DEAD_CNT (DEAD_CNT)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .cyc_start   (cyc_start),
    .pk_trip     (pk_trip),
    .zc_det      (zc_det),
    .fccm        (fccm),
    .before_cap  (before_cap),
    .at_cap      (at_cap),
    .refresh_cyc (refresh_cyc),
    .dt_done     (dt_done),
    .dt_active   (dt_active),
    .hs_gate     (hs_gate),
    .ls_gate     (ls_gate),
    .dropout     (dropout)
  );

endmodule

// File: tb/buck_cycle_seq_tb.sv
`timescale 1ns/1ps
module buck_cycle_seq_tb;

  localparam int CYC = 200;
  localparam int DT  = 4;
  localparam int CAP = (CYC * 95) / 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, cyc_start = 1'b0, pk_trip = 1'b0, zc_det = 1'b0, fccm = 1'b1;
  logic hs_gate, ls_gate, dropout;

  int n_checks = 0;
  int n_fail   = 0;
  int k        = 0;
  int overlap  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  buck_cycle_seq u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cyc_start(cyc_start),
    .pk_trip(pk_trip), .zc_det(zc_det), .fccm(fccm),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .dropout(dropout)
  );

  task automatic check(string req, logic act, logic exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b (pos %0d)", req, what, act, exp, k);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    k++;
    if (hs_gate && ls_gate) overlap++;
  endtask

  task automatic start_cycle();
    cyc_start = 1'b1;
    tick();
    cyc_start = 1'b0;
    k = 0;
  endtask

  task automatic wait_to(int kk);
    while (k < kk) tick();
  endtask

  task automatic t_reset();
    check("R1", hs_gate, 1'b0, "hs in reset");
    check("R1", ls_gate, 1'b0, "ls in reset");
    check("R1", dropout, 1'b0, "dropout in reset");
    rst_n = 1'b1;
    en = 1'b1;
    tick(); tick();
    check("R2", hs_gate, 1'b0, "hs before first start");
  endtask

  task automatic t_normal();
    fccm = 1'b1;
    start_cycle();
    check("R2", hs_gate, 1'b1, "hs at position 0");
    wait_to(10);
    pk_trip = 1'b1;
    tick();
    pk_trip = 1'b0;
    check("R3", hs_gate, 1'b0, "hs after trip");
    check("R3", ls_gate, 1'b0, "ls first dead period");
    tick(); tick(); tick();
    check("R3", ls_gate, 1'b0, "ls last dead period");
    tick();
    check("R3", ls_gate, 1'b1, "ls after dead time");
    wait_to(CYC - 1);
    check("R4", ls_gate, 1'b1, "ls held to cycle end");
    start_cycle();
    check("R4", ls_gate, 1'b0, "ls at cycle start");
    check("R4", hs_gate, 1'b0, "hs in dead time");
    tick(); tick(); tick();
    check("R4", hs_gate, 1'b0, "hs last dead period");
    tick();
    check("R4", hs_gate, 1'b1, "hs after dead time");
    wait_to(50);
    pk_trip = 1'b1;
    tick();
    pk_trip = 1'b0;
    wait_to(100);
    check("R3", ls_gate, 1'b1, "ls on in second cycle");
  endtask

  task automatic t_zero_cross();
    zc_det = 1'b1;
    tick();
    check("R6", ls_gate, 1'b1, "ls kept with forced-continuous");
    fccm = 1'b0;
    tick();
    zc_det = 1'b0;
    check("R5", ls_gate, 1'b0, "ls off after zero crossing");
    wait_to(CYC - 1);
    check("R5", ls_gate, 1'b0, "ls rests to cycle end");
    check("R5", hs_gate, 1'b0, "hs rests to cycle end");
    start_cycle();
    check("R5", hs_gate, 1'b1, "hs immediately after rest");
    fccm = 1'b1;
    wait_to(CYC - 1);
  endtask

  task automatic t_dropout();
    en = 1'b0;
    tick();
    check("R1", hs_gate, 1'b0, "hs when disabled");
    en = 1'b1;
    tick();
    // cycle 0: no trip
    start_cycle();
    wait_to(CAP - 1);
    check("R7", dropout, 1'b0, "dropout before cap point");
    tick();
    check("R7", dropout, 1'b1, "dropout at cap point");
    check("R7", hs_gate, 1'b1, "hs beyond cap in cycle 0");
    wait_to(CYC - 1);
    start_cycle();
    check("R7", hs_gate, 1'b1, "hs held across start");
    wait_to(CYC - 1);
    // disable mid-run: numbering restarts
    en = 1'b0;
    tick();
    check("R1", hs_gate, 1'b0, "hs cleared by disable");
    check("R1", dropout, 1'b0, "dropout cleared by disable");
    en = 1'b1;
    tick();
    for (int c = 0; c < 3; c++) begin
      start_cycle();
      wait_to(CYC - 1);
      check("R1", hs_gate, 1'b1, "hs uncapped in cycles 0..2 after restart");
    end
    // cycle 3: refresh
    start_cycle();
    wait_to(CAP - 1);
    check("R8", hs_gate, 1'b1, "hs before cap in refresh cycle");
    tick();
    check("R8", hs_gate, 1'b0, "hs off at cap in refresh cycle");
    wait_to(CAP + DT - 1);
    check("R8", ls_gate, 1'b0, "ls in refresh dead time");
    tick();
    check("R8", ls_gate, 1'b1, "ls in refresh window");
    check("R8", dropout, 1'b1, "dropout kept through refresh");
    wait_to(CYC - 1);
    check("R8", ls_gate, 1'b1, "ls held to end of refresh cycle");
    // cycle 0 again: leave dropout
    start_cycle();
    wait_to(DT);
    check("R4", hs_gate, 1'b1, "hs after refresh dead time");
    wait_to(50);
    pk_trip = 1'b1;
    tick();
    pk_trip = 1'b0;
    check("R9", dropout, 1'b0, "dropout cleared by early trip");
    wait_to(CYC - 1);
    // cycle 1: trip exactly at last position before cap
    start_cycle();
    wait_to(CAP - 1);
    pk_trip = 1'b1;
    tick();
    pk_trip = 1'b0;
    check("R9", dropout, 1'b0, "trip at cap point keeps dropout low");
    check("R9", hs_gate, 1'b0, "hs off after trip at cap point");
    wait_to(CYC - 1);
  endtask

  initial begin
    tick(); tick();
    t_reset();
    t_normal();
    t_zero_cross();
    t_dropout();
    check("R10", (overlap == 0), 1'b1, "gates never overlap");
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    end
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule